// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

The block turns parallel words written by a processor into an asynchronous NRZ serial stream on one output line. A word written to the port lands in a holding register. When the shift register is free, the word moves into it in one clock cycle. Because of this, a second word can wait while the first one is on the line, and frames can go out with no idle gap between them. Each frame is one low start bit, then 8 or 9 data bits sent least significant bit first, then one high stop bit. The block generates no parity. In 9-bit mode the extra bit is whatever software supplied with the word.

The bit rate comes from a free-running down-counter. The counter reloads from a programmable period value and gives one tick every (period+1) clocks. A speed select sets how many ticks make one bit: 16 or 64. Two status outputs tell software what state the block is in. The buffer-empty flag says the holding register can take a word; it drives the interrupt output through an interrupt enable. The shifter-empty status says no frame is in progress; it is polled only and drives no interrupt.

Top module: `dbuf_serial_tx`

## Requirements
- R1: The line idles high. In 8-bit mode (`nine_mode`=0) a frame is a low start bit, then `wr_data[0]` through `wr_data[7]` in that order, then a high stop bit, for 10 bit times in all.
- R2: In 9-bit mode (`nine_mode`=1) the value of `wr_ninth` captured with the word is sent after `wr_data[7]` and before the stop bit, for 11 bit times in all.
- R3: One bit time is (period+1)*16 clocks when `slow_sel`=0 and (period+1)*64 clocks when `slow_sel`=1.
- R4: While `tx_en` is low no frame starts and `txd` stays high. A word written while disabled is held, and it is sent once `tx_en` is set.
- R5: When the shifter is empty and `tx_en` is high, a word written in cycle n has `buf_empty` low after the clock edge that ends cycle n, and `buf_empty` high with `shift_empty` low after the following edge.
- R6: A word that is queued while a frame is being sent starts its start bit on the same clock on which the previous stop bit ends. Two such start bits are therefore exactly one frame length apart.
- R7: `buf_empty` is high after reset. It goes low only on a write. It goes high when the word moves to the shifter, whatever `irq_en` is. `irq` equals `buf_empty` AND `irq_en`.
- R8: `shift_empty` is high when no frame is held. It is low from the transfer into the shifter until the stop bit ends. While it is high, `txd` is high.
- R9: Clearing `tx_en` puts `txd` and `shift_empty` high after the next clock edge and drops the frame in progress. A word in the holding register is kept, and it is sent after re-enable.
- R10: After reset, `txd`=1, `buf_empty`=1, `shift_empty`=1 and `irq`=`irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| irq_en | input | 1 | Interrupt enable for the buffer-empty flag |
| nine_mode | input | 1 | 1 = 9 data bits per frame, 0 = 8 |
| slow_sel | input | 1 | 1 = 64 ticks per bit, 0 = 16 ticks per bit |
| period | input | DIV_W | Baud counter reload value |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Data word to send |
| wr_ninth | input | 1 | Ninth bit captured with the word |
| buf_empty | output | 1 | Holding register is free |
| irq | output | 1 | Interrupt: buf_empty AND irq_en |
| shift_empty | output | 1 | No frame in the shift register |
| txd | output | 1 | Serial output line |

## Verification
The assertions assume that `period`, `slow_sel` and `nine_mode` change only while both `buf_empty` and `shift_empty` are high. The bench keeps to this: it changes the configuration only after it has waited for both flags. The assertions also assume that `wr_stb` is a single-cycle pulse. The bench drives it for exactly one clock per word. It writes a second word only after the first has left the holding register, or, in the disable test, on purpose while a frame is in progress.

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx #(
  parameter int DIV_W      = 8,
  parameter int DATA_W     = 8,
  parameter int FAST_RATIO = 16,
  parameter int SLOW_RATIO = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              irq_en,
  input  logic              nine_mode,
  input  logic              slow_sel,
  input  logic [DIV_W-1:0]  period,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ninth,
  output logic              buf_empty,
  output logic              irq,
  output logic              shift_empty,
  output logic              txd
);
  localparam int FRM_W = DATA_W + 3;
  localparam int SUB_W = $clog2(SLOW_RATIO);
  localparam int CNT_W = $clog2(FRM_W + 1);
  localparam logic [SUB_W-1:0] FAST_LIM = SUB_W'(FAST_RATIO - 1);
  localparam logic [SUB_W-1:0] SLOW_LIM = SUB_W'(SLOW_RATIO - 1);

  logic [DIV_W-1:0]  div_q;
  logic [SUB_W-1:0]  sub_q;
  logic              tick, bit_stb;
  logic [SUB_W-1:0]  lim;

  logic              hold_full;
  logic [DATA_W-1:0] hold_d;
  logic              hold_n9;

  logic [FRM_W-1:0]  sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, started_q;
  logic              done, xfer;

  assign tick    = (div_q == '0);
  assign lim     = slow_sel ? SLOW_LIM : FAST_LIM;
  assign bit_stb = tick && (sub_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      sub_q <= '0;
    end else begin
      div_q <= tick ? period : div_q - 1'b1;
      if (tick) sub_q <= (sub_q >= lim) ? '0 : sub_q + 1'b1;
    end
  end

  assign done = busy_q && started_q && bit_stb && (cnt_q == CNT_W'(1));
  assign xfer = tx_en && hold_full && (!busy_q || done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_d    <= '0;
      hold_n9   <= 1'b0;
    end else begin
      hold_full <= (hold_full && !xfer) || wr_stb;
      if (wr_stb) begin
        hold_d  <= wr_data;
        hold_n9 <= wr_ninth;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q      <= '1;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      started_q <= 1'b0;
    end else if (!tx_en) begin
      busy_q    <= 1'b0;
      started_q <= 1'b0;
    end else if (xfer) begin
      sh_q      <= {1'b1, nine_mode ? hold_n9 : 1'b1, hold_d, 1'b0};
      cnt_q     <= nine_mode ? CNT_W'(FRM_W) : CNT_W'(FRM_W - 1);
      busy_q    <= 1'b1;
      started_q <= busy_q;
    end else if (busy_q && bit_stb) begin
      if (!started_q) begin
        started_q <= 1'b1;
      end else if (cnt_q == CNT_W'(1)) begin
        busy_q    <= 1'b0;
        started_q <= 1'b0;
      end else begin
        sh_q  <= {1'b1, sh_q[FRM_W-1:1]};
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign buf_empty   = !hold_full;
  assign irq         = buf_empty && irq_en;
  assign shift_empty = !busy_q;
  assign txd         = (busy_q && started_q) ? sh_q[0] : 1'b1;

  // R7
  buf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_empty) |-> $past(wr_stb));
  // R7
  buf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(tx_en) && !shift_empty);
  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txd && shift_empty);
  // R8
  empty_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd);
  // R3
  line_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_stb) || !$past(tx_en));
  // R8
  shift_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_empty) |-> $past(bit_stb) || !$past(tx_en));
endmodule

// File: tb/dbuf_serial_tx_tb.sv
module dbuf_serial_tx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, irq_en = 0, nine_mode = 0, slow_sel = 0, wr_stb = 0, wr_ninth = 0;
  logic [7:0] period = 0, wr_data = 0;
  logic buf_empty, irq, shift_empty, txd;

  int tests = 0, fails = 0, cyc = 0;
  int cur_T = 16, cur_L = 10;
  logic [8:0] rx_q[$];
  int rx_t[$];
  bit rx_ok[$];
  localparam int LIMIT = 190000;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbuf_serial_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en), .nine_mode(nine_mode),
    .slow_sel(slow_sel), .period(period), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_ninth(wr_ninth), .buf_empty(buf_empty), .irq(irq), .shift_empty(shift_empty), .txd(txd));

  function automatic [8:0] exp_word(input [7:0] d, input bit n9, input bit mode);
    return {mode ? n9 : 1'b0, d};
  endfunction
  function automatic int bit_time(input int p, input bit slow);
    return (p + 1) * (slow ? 64 : 16);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin : frame
        logic [10:0] b;
        int t0, T, L;
        t0 = cyc; T = cur_T; L = cur_L; b = '1;
        repeat (T / 2) @(negedge clk);
        b[0] = txd;
        for (int k = 1; k < L; k++) begin
          repeat (T) @(negedge clk);
          b[k] = txd;
        end
        rx_q.push_back({(L == 11) ? b[9] : 1'b0, b[8:1]});
        rx_t.push_back(t0);
        rx_ok.push_back(b[0] == 1'b0 && b[L-1] == 1'b1);
      end
    end
  end

  task automatic write_word(input [7:0] d, input bit n9);
    @(negedge clk);
    wr_data = d; wr_ninth = n9; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    while (rx_q.size() < n && cyc < LIMIT) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!(buf_empty && shift_empty) && cyc < LIMIT) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic configure(input int p, input bit slow, input bit mode);
    period = 8'(p); slow_sel = slow; nine_mode = mode;
    cur_T = bit_time(p, slow); cur_L = mode ? 11 : 10;
    repeat (cur_T + 4) @(negedge clk);
  endtask

  task automatic clear_q();
    rx_q.delete(); rx_t.delete(); rx_ok.delete();
  endtask

  task automatic check_frame(input int idx, input [8:0] exp, input string req);
    if (rx_q.size() > idx) begin
      chk(rx_q[idx] == exp, req, rx_q[idx], exp);
      chk(rx_ok[idx], {req, " start/stop"}, rx_ok[idx], 1);
    end else chk(0, {req, " frame missing"}, rx_q.size(), idx + 1);
  endtask

  initial begin
    bit high_all;
    void'($urandom(32'h5EED_0042));
    irq_en = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(txd == 1, "R10 txd", txd, 1);
    chk(buf_empty == 1, "R10 buf_empty", buf_empty, 1);
    chk(shift_empty == 1, "R10 shift_empty", shift_empty, 1);
    chk(irq == 1, "R10 irq", irq, 1);

    // R4: write while disabled, nothing sent
    configure(0, 0, 0);
    irq_en = 1'b0;
    write_word(8'hA5, 0);
    chk(buf_empty == 0, "R7 write clears flag", buf_empty, 0);
    chk(irq == 0, "R7 irq masked", irq, 0);
    high_all = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || shift_empty !== 1'b1) high_all = 0;
      irq_en = i[3];
    end
    chk(high_all, "R4 no frame while disabled", high_all, 1);
    chk(buf_empty == 0, "R7 flag not cleared except by write", buf_empty, 0);
    irq_en = 1'b1;
    chk(irq == 0, "R7 irq follows flag", irq, 0);
    tx_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(buf_empty == 1, "R7 transfer sets flag", buf_empty, 1);
    chk(irq == 1, "R7 irq with enable", irq, 1);
    wait_frames(1);
    check_frame(0, exp_word(8'hA5, 0, 0), "R4 enable after write / R1");
    wait_idle(); clear_q();

    // R6 back-to-back with 9-bit mode, slow speed
    configure(1, 1, 1);
    write_word(8'h3C, 1);
    @(negedge clk);
    write_word(8'hC3, 0);
    chk(buf_empty == 0, "R7 second word waits", buf_empty, 0);
    chk(shift_empty == 0, "R8 busy during frame", shift_empty, 0);
    wait_frames(2);
    check_frame(0, exp_word(8'h3C, 1, 1), "R2 first");
    check_frame(1, exp_word(8'hC3, 0, 1), "R2 second");
    if (rx_t.size() > 1)
      chk(rx_t[1] - rx_t[0] == 11 * 128, "R6/R3 frame spacing", rx_t[1] - rx_t[0], 11 * 128);
    wait_idle(); clear_q();

    // Random frames
    for (int it = 0; it < 12; it++) begin
      int p; bit s, m, pair; logic [7:0] d0, d1; bit n0, n1;
      p = int'($urandom_range(2, 0)); s = 1'($urandom_range(1, 0));
      m = 1'($urandom_range(1, 0)); pair = 1'($urandom_range(1, 0));
      d0 = 8'($urandom); d1 = 8'($urandom);
      n0 = 1'($urandom_range(1, 0)); n1 = 1'($urandom_range(1, 0));
      irq_en = 1'($urandom_range(1, 0));
      configure(p, s, m);
      write_word(d0, n0);
      chk(buf_empty == 0, "R5 flag low after write", buf_empty, 0);
      @(negedge clk);
      chk(buf_empty == 1 && shift_empty == 0, "R5 pass-through", {buf_empty, shift_empty}, 2);
      chk(irq == irq_en, "R7 irq gate", irq, irq_en);
      if (pair) write_word(d1, n1);
      wait_frames(pair ? 2 : 1);
      check_frame(0, exp_word(d0, n0, m), m ? "R2 random" : "R1 random");
      if (pair) begin
        check_frame(1, exp_word(d1, n1, m), "R6 random second");
        if (rx_t.size() > 1)
          chk(rx_t[1] - rx_t[0] == cur_L * cur_T, "R3 random spacing",
              rx_t[1] - rx_t[0], cur_L * cur_T);
      end
      wait_idle();
      chk(rx_q.size() == (pair ? 2 : 1), "R8 no extra frames", rx_q.size(), pair ? 2 : 1);
      clear_q();
    end

    // R9 disable mid-frame keeps held word
    configure(0, 0, 0);
    write_word(8'h81, 0);
    @(negedge clk);
    write_word(8'h7E, 0);
    repeat (60) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd == 1 && shift_empty == 1, "R9 disable idles line", {txd, shift_empty}, 3);
    chk(buf_empty == 0, "R9 held word kept", buf_empty, 0);
    repeat (300) @(negedge clk);
    clear_q();
    tx_en = 1'b1;
    wait_frames(1);
    check_frame(0, exp_word(8'h7E, 0, 0), "R9 held word sent");
    wait_idle();
    chk(rx_q.size() == 1, "R9 single frame", rx_q.size(), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc >= LIMIT);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule